// File: doc/BRIEF.md
# Decade Divider Counter

This block is a small counter made of two sections that share one reset: a divide-by-two section whose state appears on `qa`, and a divide-by-five section whose state appears on `qb`, `qc` and `qd`. Each section steps when its own count input goes from high to low. Both count inputs are asynchronous to the block. They pass through a synchronizer and a falling-edge detector that run on one fast system clock, so every flop in the design is clocked by that clock.

A two-bit mode input picks how the sections connect. In split mode the two sections run on their own inputs. In decade mode the two-state section feeds the five-state one, and the four outputs form a binary-coded decimal digit. In bi-quinary mode the five-state section takes the external input and feeds the two-state section, so `qa` becomes a square wave at one tenth of the input rate. A one-cycle flag, `tc`, marks each return of the chained count to zero. A dual unit is simply two instances of this block.

Top module: `decade_divider`

## Requirements
- R1: `rst` is active high and asynchronous. While it is high, `qa`, `qb`, `qc`, `qd` and `tc` are all 0, and falling edges on either count input change nothing.
- R2: The five-state value {qd,qc,qb} (qd is the most significant bit) steps 0,1,2,3,4 and then returns to 0. Each step happens on a falling edge of its driving input. In split mode that input is `cnt_b`.
- R3: In split mode, `qa` toggles on each falling edge of `cnt_a`.
- R4: In split mode the sections are independent. Edges on `cnt_a` leave {qd,qc,qb} unchanged, edges on `cnt_b` leave `qa` unchanged, and falling edges on both inputs in the same cycle step both sections.
- R5: The mode encoding is 00 for split, 01 for decade and 10 for bi-quinary. Mode 11 behaves exactly as split mode.
- R6: In decade mode (01), falling edges of `cnt_a` drive the count. {qd,qc,qb,qa} counts in binary from 0 to 9 and returns to 0. Edges on `cnt_b` are ignored.
- R7: In bi-quinary mode (10), falling edges of `cnt_b` drive the five-state section, and `qa` toggles only when `qd` falls. The weighted value qa*8+{qd,qc,qb} runs 0 to 4 and then 8 to 12. Edges on `cnt_a` are ignored.
- R8: `tc` is high for exactly one cycle, in the cycle in which the outputs first show the wrapped value. It fires when {qd,qc,qb} returns from 4 to 0, and in bi-quinary mode only when `qa` was 1 at that moment.
- R9: A falling edge on a count input changes the outputs on the third rising edge of `clk` after the input falls. A rising edge changes nothing. A chained section steps on the same clock edge as the section that feeds it.
- R10: A falling edge that occurs in the same cycle that `rst` is released is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than both count inputs |
| rst | input | 1 | Asynchronous active-high reset of both sections |
| mode | input | 2 | 00 split, 01 decade, 10 bi-quinary, 11 split |
| cnt_a | input | 1 | Count input of the two-state section |
| cnt_b | input | 1 | Count input of the five-state section |
| qa | output | 1 | State of the two-state section |
| qb | output | 1 | Five-state value bit 0 |
| qc | output | 1 | Five-state value bit 1 |
| qd | output | 1 | Five-state value bit 2 (most significant) |
| tc | output | 1 | One-cycle pulse when the chained count wraps to zero |

## Verification
The interesting coincidence is a section's own step landing on the same clock edge as the carry from its neighbour. In decade mode, count 1 to 2 (`qa` falling while {qd,qc,qb} steps) and count 9 to 0 (both sections wrap while `tc` rises) must appear as one jump with no intermediate value. The bench samples these one cycle apart and compares them with a decimal model. In split mode, falling edges on both count inputs are driven in the same cycle, and both sections must advance on the same edge. A falling edge is also placed exactly where reset is released, to confirm that it is dropped.

// File: rtl/decdiv_pkg.sv
package decdiv_pkg;

  typedef enum logic [1:0] {
    MODE_SPLIT = 2'b00,
    MODE_BCD   = 2'b01,
    MODE_BIQ   = 2'b10,
    MODE_SPARE = 2'b11
  } mode_e;

  localparam int LO_MOD = 2;
  localparam int HI_MOD = 5;
  localparam int LO_W   = $clog2(LO_MOD);
  localparam int HI_W   = $clog2(HI_MOD);

endpackage

// File: rtl/decdiv_fall_det.sv
module decdiv_fall_det #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic fall
);
  // Synchronizer chain followed by one history flop.
  // All flops clear to 0, so no edge can be seen straight after reset.
  logic [STAGES-1:0] sync_q;
  logic              hist_q;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      sync_q <= '0;
      hist_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], din};
      hist_q <= sync_q[STAGES-1];
    end
  end

  assign fall = hist_q & ~sync_q[STAGES-1];

endmodule

// File: rtl/decdiv_modn.sv
module decdiv_modn #(
  parameter int MOD = 5,
  parameter int W   = $clog2(MOD)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] LAST = W'(MOD - 1);

  always_ff @(posedge clk or posedge rst) begin
    if (rst)
      cnt <= '0;
    else if (step)
      cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
  end

endmodule

// File: rtl/decdiv_route.sv
module decdiv_route
  import decdiv_pkg::*;
(
  input  logic [1:0]      mode,
  input  logic            fall_a,
  input  logic            fall_b,
  input  logic [LO_W-1:0] lo_cnt,
  input  logic [HI_W-1:0] hi_cnt,
  output logic            lo_step,
  output logic            hi_step,
  output logic            wrap_set
);
  localparam logic [LO_W-1:0] LO_LAST = LO_W'(LO_MOD - 1);
  localparam logic [HI_W-1:0] HI_LAST = HI_W'(HI_MOD - 1);

  logic lo_at_last;
  logic hi_at_last;

  assign lo_at_last = (lo_cnt == LO_LAST);
  assign hi_at_last = (hi_cnt == HI_LAST);

  // A chained section steps in the same cycle as its feeding section wraps.
  always_comb begin
    case (mode_e'(mode))
      MODE_BCD: begin
        lo_step  = fall_a;
        hi_step  = fall_a & lo_at_last;
        wrap_set = hi_step & hi_at_last;
      end
      MODE_BIQ: begin
        hi_step  = fall_b;
        lo_step  = fall_b & hi_at_last;
        wrap_set = hi_step & hi_at_last & lo_at_last;
      end
      default: begin
        lo_step  = fall_a;
        hi_step  = fall_b;
        wrap_set = hi_step & hi_at_last;
      end
    endcase
  end

endmodule

// File: rtl/decade_divider.sv
module decade_divider
  import decdiv_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode,
  input  logic       cnt_a,
  input  logic       cnt_b,
  output logic       qa,
  output logic       qb,
  output logic       qc,
  output logic       qd,
  output logic       tc
);
  localparam int NUM_IN = 2;

  logic [NUM_IN-1:0] raw_in;
  logic [NUM_IN-1:0] falls;
  logic [LO_W-1:0]   lo_cnt;
  logic [HI_W-1:0]   hi_cnt;
  logic              lo_step;
  logic              hi_step;
  logic              wrap_set;

  assign raw_in = {cnt_b, cnt_a};

  for (genvar i = 0; i < NUM_IN; i++) begin : g_edge
    decdiv_fall_det #(.STAGES(SYNC_STAGES)) u_fall (
      .clk  (clk),
      .rst  (rst),
      .din  (raw_in[i]),
      .fall (falls[i])
    );
  end

  decdiv_route u_route (
    .mode     (mode),
    .fall_a   (falls[0]),
    .fall_b   (falls[1]),
    .lo_cnt   (lo_cnt),
    .hi_cnt   (hi_cnt),
    .lo_step  (lo_step),
    .hi_step  (hi_step),
    .wrap_set (wrap_set)
  );

  decdiv_modn #(.MOD(LO_MOD), .W(LO_W)) u_lo (
    .clk  (clk),
    .rst  (rst),
    .step (lo_step),
    .cnt  (lo_cnt)
  );

  decdiv_modn #(.MOD(HI_MOD), .W(HI_W)) u_hi (
    .clk  (clk),
    .rst  (rst),
    .step (hi_step),
    .cnt  (hi_cnt)
  );

  always_ff @(posedge clk or posedge rst) begin
    if (rst) tc <= 1'b0;
    else     tc <= wrap_set;
  end

  assign qa = lo_cnt[0];
  assign qb = hi_cnt[0];
  assign qc = hi_cnt[1];
  assign qd = hi_cnt[2];

endmodule

// File: rtl/decade_divider_chk.sv
module decade_divider_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] mode,
  input logic       qa,
  input logic       qb,
  input logic       qc,
  input logic       qd,
  input logic       tc
);
  logic [2:0] five;
  assign five = {qd, qc, qb};

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |-> (!qa && !qb && !qc && !qd && !tc));

  p_five_step_r2: assert property (@(posedge clk) disable iff (rst)
    (five != $past(five)) |->
      (five == (($past(five) == 3'd4) ? 3'd0 : $past(five) + 3'd1)));

  p_biq_toggle_r7: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b10 && $past(mode) == 2'b10 && qa != $past(qa)) |->
      ($past(qd) && !qd));

  p_tc_single_r8: assert property (@(posedge clk) disable iff (rst)
    tc |=> !tc);

  p_tc_at_zero_r8: assert property (@(posedge clk) disable iff (rst)
    tc |-> (five == 3'd0));

endmodule

bind decade_divider decade_divider_chk u_chk (
  .clk  (clk),
  .rst  (rst),
  .mode (mode),
  .qa   (qa),
  .qb   (qb),
  .qc   (qc),
  .qd   (qd),
  .tc   (tc)
);

// File: tb/decade_divider_bench.sv
module decade_divider_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] mode = 2'b00;
  logic       cnt_a = 1'b0;
  logic       cnt_b = 1'b0;
  logic       qa, qb, qc, qd, tc;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  decade_divider u_decade_divider (
    .clk(clk), .rst(rst), .mode(mode), .cnt_a(cnt_a), .cnt_b(cnt_b),
    .qa(qa), .qb(qb), .qc(qc), .qd(qd), .tc(tc)
  );

  task automatic chk(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  function automatic int five_v();
    return int'({qd, qc, qb});
  endfunction

  task automatic do_reset(input logic [1:0] m);
    @(negedge clk);
    rst = 1'b1; cnt_a = 1'b0; cnt_b = 1'b0; mode = m;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  // High for three cycles, then low; samples one half cycle after the
  // third rising edge that follows the fall.
  task automatic pulse(input bit on_a, input bit on_b);
    @(negedge clk);
    if (on_a) cnt_a = 1'b1;
    if (on_b) cnt_b = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    if (on_a) cnt_a = 1'b0;
    if (on_b) cnt_b = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset_state;
    do_reset(2'b00);
    chk("R1 outputs after reset", int'({qd, qc, qb, qa}), 0);
    chk("R1 tc after reset", int'(tc), 0);
  endtask

  task automatic t_split_five;
    do_reset(2'b00);
    for (int i = 1; i <= 7; i++) begin
      pulse(1'b0, 1'b1);
      chk("R2 five-state value", five_v(), i % 5);
      chk("R4 qa untouched by cnt_b", int'(qa), 0);
      chk("R8 tc on five-state wrap", int'(tc), (i % 5 == 0) ? 1 : 0);
      if (i == 5) begin
        @(negedge clk);
        chk("R8 tc lasts one cycle", int'(tc), 0);
      end
    end
  endtask

  task automatic t_split_two;
    do_reset(2'b00);
    for (int i = 1; i <= 3; i++) begin
      pulse(1'b1, 1'b0);
      chk("R3 qa toggles", int'(qa), i % 2);
      chk("R4 five-state untouched by cnt_a", five_v(), 0);
      chk("R8 no tc from cnt_a", int'(tc), 0);
    end
    pulse(1'b1, 1'b1);
    chk("R4 both step together: qa", int'(qa), 0);
    chk("R4 both step together: five", five_v(), 1);
  endtask

  task automatic t_mode11;
    do_reset(2'b11);
    pulse(1'b0, 1'b1);
    pulse(1'b0, 1'b1);
    chk("R5 mode 11 five-state", five_v(), 2);
    chk("R5 mode 11 qa held", int'(qa), 0);
    pulse(1'b1, 1'b0);
    chk("R5 mode 11 qa", int'(qa), 1);
    chk("R5 mode 11 five held", five_v(), 2);
  endtask

  task automatic t_bcd;
    do_reset(2'b01);
    for (int i = 1; i <= 10; i++) begin
      pulse(1'b1, 1'b0);
      chk("R6 decade count", int'({qd, qc, qb, qa}), i % 10);
      chk("R8 decade tc", int'(tc), (i == 10) ? 1 : 0);
      if (i == 4) begin
        pulse(1'b0, 1'b1);
        chk("R6 cnt_b ignored in decade mode", int'({qd, qc, qb, qa}), 4);
      end
    end
    @(negedge clk);
    chk("R8 decade tc one cycle", int'(tc), 0);
  endtask

  task automatic t_biq;
    do_reset(2'b10);
    for (int i = 1; i <= 10; i++) begin
      int idx;
      idx = i % 10;
      pulse(1'b0, 1'b1);
      chk("R7 bi-quinary weighted value", int'(qa) * 8 + five_v(),
          (idx >= 5) ? 8 + (idx - 5) : idx);
      chk("R8 bi-quinary tc", int'(tc), (i == 10) ? 1 : 0);
      if (i == 3) begin
        pulse(1'b1, 1'b0);
        chk("R7 cnt_a ignored in bi-quinary mode",
            int'(qa) * 8 + five_v(), 3);
      end
    end
  endtask

  task automatic t_latency;
    do_reset(2'b00);
    @(negedge clk);
    cnt_b = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R9 rising edge no change", five_v(), 0);
    cnt_b = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R9 unchanged after two edges", five_v(), 0);
    @(posedge clk);
    @(negedge clk);
    chk("R9 stepped on third edge", five_v(), 1);
  endtask

  task automatic t_reset_mid;
    do_reset(2'b01);
    pulse(1'b1, 1'b0);
    pulse(1'b1, 1'b0);
    pulse(1'b1, 1'b0);
    chk("R6 count before reset", int'({qd, qc, qb, qa}), 3);
    @(negedge clk);
    rst = 1'b1;
    #1;
    chk("R1 asynchronous clear", int'({qd, qc, qb, qa}), 0);
    pulse(1'b1, 1'b0);
    chk("R1 edges blocked in reset", int'({qd, qc, qb, qa}), 0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_release_edge;
    @(negedge clk);
    rst = 1'b1; mode = 2'b00; cnt_b = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    cnt_b = 1'b0;
    rst = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk("R10 edge at reset release dropped", five_v(), 0);
  endtask

  initial begin
    t_reset_state();
    t_split_five();
    t_split_two();
    t_mode11();
    t_bcd();
    t_biq();
    t_latency();
    t_reset_mid();
    t_release_edge();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule